// File: doc/BRIEF.md
# Header Padder with Nonce Sweep

This block turns an 80-byte block header into the single padded 128-byte message block that a 512-bit compression core consumes, and repeats that for a run of consecutive nonces. Software-side logic loads the header as 32-bit words, then starts a sweep with a first nonce and a nonce count. For each nonce the block places the nonce, big-endian, in the last four header bytes, launches the external compression core with the fixed initial chaining value and a bit counter of 640, waits for the core's digest, and streams that digest out as sixteen byte-swapped 32-bit words.

The external core is reached through a start/done handshake: the core samples the block, chaining value and counter in the cycle `core_start` is high, and later presents the eight 64-bit digest lanes in the cycle it raises `core_done`. The digest stream uses valid/ready handshaking, and a stalled stream holds back the next compression launch. Each streamed word carries the nonce's position in the sweep, so a consumer can place the digest for nonce n at index n minus the first nonce.

Top module: `hdr_sweep_top`

## Requirements
- R1: Block byte b (bits 8b+7..8b of `core_block`) for b in 0..75 equals byte b%4 (bits 8(b%4)+7..8(b%4)) of header word b/4; header word 19 never reaches the block.
- R2: Block bytes 80..127 are zero except byte 80 = 0x80, byte 111 = 0x01, byte 126 = 0x02 and byte 127 = 0x80.
- R3: Block bytes 76, 77, 78, 79 carry nonce bits 31..24, 23..16, 15..8, 7..0 respectively.
- R4: Each nonce gets exactly one single-cycle `core_start`, with `core_counter` = 640 and `core_chain` lane i (bits 64i+63..64i) equal to the i-th standard 512-bit initial chaining constant (lane 0 = 0x6a09e667f3bcc908, lane 1 = 0xbb67ae8584caa73b, lane 2 = 0x3c6ef372fe94f82b, lane 3 = 0xa54ff53a5f1d36f1, lanes 4..7 = 0x510e527fade682d1, 0x9b05688c2b3e6c1f, 0x1f83d9abfb41bd6b, 0x5be0cd19137e2179).
- R5: For digest lane h[i] = `core_digest` bits 64i+63..64i, output word 2i is the byte-reversed h[i][63:32] and word 2i+1 the byte-reversed h[i][31:0]; `dig_last` is high only on word 15.
- R6: A sweep processes nonces start, start+1, ... for exactly count nonces, incrementing modulo 2^32, and every word of the k-th nonce carries `dig_slot` = k (starting at 0).
- R7: While `dig_valid` is high and `dig_ready` low, `dig_valid` and `dig_data` hold; no `core_start` is issued while any digest word is still unaccepted.
- R8: `sweep_done` rises after the last word of the last nonce is accepted, stays high with `sweep_busy` low until the next accepted start, and clears on that start when count is nonzero.
- R9: A start with count 0 raises `sweep_done` on the next cycle without any `core_start` or output word.
- R10: A start pulse while `sweep_busy` is high is ignored; the running sweep's nonces, slots and length are unchanged.
- R11: Header writes with an address of 19 or above leave the block's header bytes unchanged.
- R12: After reset `dig_valid`, `core_start`, `sweep_busy` and `sweep_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_wr_en | input | 1 | Header word write strobe |
| hdr_wr_addr | input | 5 | Header word index |
| hdr_wr_data | input | 32 | Header word, byte 0 in bits 7..0 |
| sweep_start | input | 1 | Start pulse for a nonce sweep |
| start_nonce | input | 32 | First nonce of the sweep |
| nonce_count | input | CNT_W | Number of nonces to process |
| sweep_busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | Last digest of the sweep accepted |
| core_start | output | 1 | Launch the compression core |
| core_block | output | 1024 | Padded message block, byte b in bits 8b+7..8b |
| core_chain | output | 512 | Initial chaining value, lane i in bits 64i+63..64i |
| core_counter | output | 64 | Bit counter for the compression (640) |
| core_done | input | 1 | Compression core result strobe |
| core_digest | input | 512 | Compression core result, lane i in bits 64i+63..64i |
| dig_valid | output | 1 | Digest word valid |
| dig_ready | input | 1 | Digest word accepted |
| dig_data | output | 32 | Byte-swapped digest word |
| dig_slot | output | CNT_W | Position of the nonce within the sweep |
| dig_last | output | 1 | Last of the sixteen words for this nonce |

## Verification
The in-line properties watch the handshake invariants every cycle: a stalled output word holds, no launch or digest capture happens while a digest is pending, a busy-time start leaves the nonce untouched, a zero-count start completes at once and out-of-range header writes leave the header bytes still. Byte placement of header, nonce and padding, the output word order, nonce wrap-around at 2^32 and the per-sweep counts of launches and words can only be shown by the bench, which rebuilds the expected block for each nonce, models the external core with a simple mixing function and compares every launched block and every accepted word under three back-pressure patterns.

// File: rtl/hdr_sweep_pkg.sv
package hdr_sweep_pkg;

   localparam int BLK_BYTES   = 128;
   localparam int HDR_BYTES   = 80;
   localparam int HDR_WORDS   = HDR_BYTES / 4;
   localparam int NONCE_BYTE0 = HDR_BYTES - 4;
   localparam int KEPT_WORDS  = NONCE_BYTE0 / 4;
   localparam int LEN_BITS    = HDR_BYTES * 8;
   localparam int DIG_LANES   = 8;
   localparam int LANE_W      = 64;
   localparam int OUT_WORDS   = DIG_LANES * 2;

   localparam logic [LANE_W-1:0] CHAIN_IV [DIG_LANES] = '{
      64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b,
      64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
      64'h510e527fade682d1, 64'h9b05688c2b3e6c1f,
      64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179
   };

   typedef enum logic [1:0] {
      SW_IDLE,
      SW_LAUNCH,
      SW_WAIT,
      SW_DRAIN
   } sweep_st_e;

   // Fixed tail of a block whose message is exactly HDR_BYTES long
   function automatic logic [7:0] pad_byte(input int b);
      case (b)
         HDR_BYTES:     return 8'h80;
         111:           return 8'h01;
         BLK_BYTES - 2: return 8'h02;
         BLK_BYTES - 1: return 8'h80;
         default:       return 8'h00;
      endcase
   endfunction

   function automatic logic [31:0] bswap32(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

endpackage

// File: rtl/hdr_block_builder.sv
module hdr_block_builder
   import hdr_sweep_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int NONCE_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [31:0]            wr_data,
   input  logic [NONCE_W-1:0]     nonce,
   output logic [BLK_BYTES*8-1:0] block
);

   localparam int KEPT_BITS = NONCE_BYTE0 * 8;

   if (NONCE_W != 32) begin : g_bad_nonce_w
      $error("hdr_block_builder: nonce must be 32 bits wide");
   end
   if ((1 << ADDR_W) < HDR_WORDS) begin : g_bad_addr_w
      $error("hdr_block_builder: address too narrow for the header");
   end

   // Only the words not overwritten by the nonce are stored
   logic [31:0] hdr_q [KEPT_WORDS];
   logic        wr_hit;

   assign wr_hit = wr_en && (int'(wr_addr) < KEPT_WORDS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < KEPT_WORDS; k++) hdr_q[k] <= '0;
      end else if (wr_hit) begin
         hdr_q[wr_addr] <= wr_data;
      end
   end

   for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
      if (b < NONCE_BYTE0) begin : g_hdr
         assign block[8*b +: 8] = hdr_q[b/4][8*(b%4) +: 8];
      end else if (b < HDR_BYTES) begin : g_nonce
         assign block[8*b +: 8] = nonce[8*(NONCE_BYTE0 + 3 - b) +: 8];
      end else begin : g_pad
         assign block[8*b +: 8] = pad_byte(b);
      end
   end

   // R11
   hdr_oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) >= KEPT_WORDS) |=> $stable(block[KEPT_BITS-1:0]));

endmodule

// File: rtl/hdr_digest_serializer.sv
module hdr_digest_serializer
   import hdr_sweep_pkg::*;
#(
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [DIG_LANES*LANE_W-1:0] digest,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [LANE_W/2-1:0]         out_data,
   output logic                        out_last
);

   localparam int IDX_W  = $clog2(OUT_WORDS);
   localparam int HALF_W = LANE_W / 2;
   localparam int OFF_W  = $clog2(DIG_LANES * LANE_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OUT_WORDS - 1);

   if (HALF_W != 32) begin : g_bad_lane
      $error("hdr_digest_serializer: lanes must split into 32-bit words");
   end

   logic [DIG_LANES*LANE_W-1:0] dig_q;
   logic [IDX_W-1:0]            idx_q;
   logic                        vld_q;
   logic                        sel_lo;
   logic [OFF_W-1:0]            bit_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dig_q <= '0;
         idx_q <= '0;
         vld_q <= 1'b0;
      end else if (load) begin
         dig_q <= digest;
         idx_q <= '0;
         vld_q <= 1'b1;
      end else if (vld_q && out_ready) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST_IDX) vld_q <= 1'b0;
      end
   end

   if (HI_FIRST) begin : g_hi_first
      assign sel_lo = idx_q[0];
   end else begin : g_lo_first
      assign sel_lo = ~idx_q[0];
   end

   assign bit_off   = {idx_q[IDX_W-1:1], ~sel_lo, 5'b0};
   assign out_data  = bswap32(dig_q[bit_off +: HALF_W]);
   assign out_valid = vld_q;
   assign out_last  = vld_q && (idx_q == LAST_IDX);

   // R7
   dig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R7
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !out_valid);

endmodule

// File: rtl/hdr_sweep_ctrl.sv
module hdr_sweep_ctrl
   import hdr_sweep_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int NONCE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NONCE_W-1:0] start_nonce,
   input  logic [CNT_W-1:0]   count,
   input  logic               core_done,
   input  logic               ser_busy,
   output logic               core_start,
   output logic               capture,
   output logic [NONCE_W-1:0] nonce,
   output logic [CNT_W-1:0]   slot,
   output logic               busy,
   output logic               done
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("hdr_sweep_ctrl: count width must be 1 to 32");
   end

   sweep_st_e          st_q;
   logic [NONCE_W-1:0] nonce_q;
   logic [CNT_W-1:0]   slot_q;
   logic [CNT_W-1:0]   left_q;
   logic               done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SW_IDLE;
         nonce_q <= '0;
         slot_q  <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         case (st_q)
            SW_IDLE: if (start) begin
               nonce_q <= start_nonce;
               slot_q  <= '0;
               left_q  <= count;
               if (count == '0) begin
                  done_q <= 1'b1;
               end else begin
                  done_q <= 1'b0;
                  st_q   <= SW_LAUNCH;
               end
            end
            SW_LAUNCH: st_q <= SW_WAIT;
            SW_WAIT:   if (core_done) st_q <= SW_DRAIN;
            SW_DRAIN:  if (!ser_busy) begin
               if (left_q == CNT_W'(1)) begin
                  done_q <= 1'b1;
                  st_q   <= SW_IDLE;
               end else begin
                  nonce_q <= nonce_q + 1'b1;
                  slot_q  <= slot_q + 1'b1;
                  left_q  <= left_q - 1'b1;
                  st_q    <= SW_LAUNCH;
               end
            end
            default: st_q <= SW_IDLE;
         endcase
      end
   end

   assign core_start = (st_q == SW_LAUNCH);
   assign capture    = (st_q == SW_WAIT) && core_done;
   assign nonce      = nonce_q;
   assign slot       = slot_q;
   assign busy       = (st_q != SW_IDLE);
   assign done       = done_q;

   // R7
   launch_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> !ser_busy);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count == '0) |=> (done && !busy));

   // R10
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SW_WAIT && start) |=> ($stable(nonce_q) && $stable(slot_q)));

endmodule

// File: rtl/hdr_sweep_top.sv
module hdr_sweep_top
   import hdr_sweep_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hdr_wr_en,
   input  logic [4:0]                  hdr_wr_addr,
   input  logic [31:0]                 hdr_wr_data,
   input  logic                        sweep_start,
   input  logic [31:0]                 start_nonce,
   input  logic [CNT_W-1:0]            nonce_count,
   output logic                        sweep_busy,
   output logic                        sweep_done,
   output logic                        core_start,
   output logic [BLK_BYTES*8-1:0]      core_block,
   output logic [DIG_LANES*LANE_W-1:0] core_chain,
   output logic [63:0]                 core_counter,
   input  logic                        core_done,
   input  logic [DIG_LANES*LANE_W-1:0] core_digest,
   output logic                        dig_valid,
   input  logic                        dig_ready,
   output logic [31:0]                 dig_data,
   output logic [CNT_W-1:0]            dig_slot,
   output logic                        dig_last
);

   logic [31:0] cur_nonce;
   logic        capture;

   hdr_block_builder #(
      .ADDR_W  (5),
      .NONCE_W (32)
   ) builder_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hdr_wr_en),
      .wr_addr (hdr_wr_addr),
      .wr_data (hdr_wr_data),
      .nonce   (cur_nonce),
      .block   (core_block)
   );

   hdr_sweep_ctrl #(
      .CNT_W   (CNT_W),
      .NONCE_W (32)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (sweep_start),
      .start_nonce (start_nonce),
      .count       (nonce_count),
      .core_done   (core_done),
      .ser_busy    (dig_valid),
      .core_start  (core_start),
      .capture     (capture),
      .nonce       (cur_nonce),
      .slot        (dig_slot),
      .busy        (sweep_busy),
      .done        (sweep_done)
   );

   hdr_digest_serializer #(
      .HI_FIRST (1'b1)
   ) ser_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (capture),
      .digest    (core_digest),
      .out_valid (dig_valid),
      .out_ready (dig_ready),
      .out_data  (dig_data),
      .out_last  (dig_last)
   );

   for (genvar i = 0; i < DIG_LANES; i++) begin : g_chain
      assign core_chain[LANE_W*i +: LANE_W] = CHAIN_IV[i];
   end

   assign core_counter = 64'(LEN_BITS);

endmodule

// File: tb/hdr_sweep_top_tb_top.sv
`timescale 1ns/1ps
module hdr_sweep_top_tb_top;

   localparam int CNT_W = 32;
   localparam int NV    = 4;
   localparam logic [31:0] V_SEED  [NV] = '{32'h0badf00d, 32'h13579bdf, 32'hc001d00d, 32'h2468ace0};
   localparam logic [31:0] V_START [NV] = '{32'h00000000, 32'h12345678, 32'hfffffffe, 32'h0000a5a5};
   localparam int          V_CNT   [NV] = '{2, 3, 3, 1};
   localparam int          V_MODE  [NV] = '{0, 1, 2, 1};
   localparam logic [511:0] TB_IV = {
      64'h5be0cd19137e2179, 64'h1f83d9abfb41bd6b, 64'h9b05688c2b3e6c1f, 64'h510e527fade682d1,
      64'ha54ff53a5f1d36f1, 64'h3c6ef372fe94f82b, 64'hbb67ae8584caa73b, 64'h6a09e667f3bcc908};

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             hdr_wr_en = 1'b0;
   logic [4:0]       hdr_wr_addr = '0;
   logic [31:0]      hdr_wr_data = '0;
   logic             sweep_start = 1'b0;
   logic [31:0]      start_nonce = '0;
   logic [CNT_W-1:0] nonce_count = '0;
   logic             sweep_busy, sweep_done, core_start;
   logic [1023:0]    core_block;
   logic [511:0]     core_chain;
   logic [63:0]      core_counter;
   logic             core_done = 1'b0;
   logic [511:0]     core_digest = '0;
   logic             dig_valid;
   logic             dig_ready = 1'b0;
   logic [31:0]      dig_data;
   logic [CNT_W-1:0] dig_slot;
   logic             dig_last;

   hdr_sweep_top #(.CNT_W(CNT_W)) dut_i (.*);

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int mode = 0;
   bit mon_en = 1'b0;
   logic [31:0] exp_start = '0;
   int k_core = 0, k_out = 0, w = 0;
   logic [31:0] hdr_mdl [20];
   bit stall_prev = 1'b0;
   logic [31:0] stall_data = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [1023:0] act, input logic [1023:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1023:0] exp_block(input logic [31:0] n);
      logic [1023:0] b = '0;
      for (int i = 0; i < 76; i++) b[8*i +: 8] = hdr_mdl[i/4][8*(i%4) +: 8];
      b[8*76 +: 8] = n[31:24];
      b[8*77 +: 8] = n[23:16];
      b[8*78 +: 8] = n[15:8];
      b[8*79 +: 8] = n[7:0];
      b[8*80 +: 8]  = 8'h80;
      b[8*111 +: 8] = 8'h01;
      b[8*126 +: 8] = 8'h02;
      b[8*127 +: 8] = 8'h80;
      return b;
   endfunction

   // Stand-in for the external compression core
   function automatic logic [511:0] fake_core(input logic [1023:0] blk,
                                              input logic [511:0] cv,
                                              input logic [63:0] ctr);
      logic [511:0] h;
      for (int i = 0; i < 8; i++)
         h[64*i +: 64] = blk[64*i +: 64] ^ {blk[64*(i+8) +: 32], blk[64*(i+8)+32 +: 32]}
                         ^ cv[64*i +: 64] ^ (ctr << i);
      return h;
   endfunction

   function automatic logic [31:0] exp_word(input int k, input int j);
      logic [511:0] h = fake_core(exp_block(exp_start + 32'(k)), TB_IV, 64'd640);
      logic [31:0] x = (j % 2 == 0) ? h[64*(j/2)+32 +: 32] : h[64*(j/2) +: 32];
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   // Core model: fixed latency of three cycles
   int cl = 0;
   logic [1023:0] lat_blk;
   logic [511:0]  lat_cv;
   logic [63:0]   lat_ctr;
   always @(posedge clk) begin
      core_done <= 1'b0;
      if (!rst_n) cl <= 0;
      else if (core_start) begin
         lat_blk <= core_block; lat_cv <= core_chain; lat_ctr <= core_counter; cl <= 3;
      end else if (cl != 0) begin
         cl <= cl - 1;
         if (cl == 1) begin
            core_done   <= 1'b1;
            core_digest <= fake_core(lat_blk, lat_cv, lat_ctr);
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      case (mode)
         0:       dig_ready <= 1'b1;
         1:       dig_ready <= cyc[0];
         default: dig_ready <= (cyc[1:0] == 2'b11);
      endcase
   end

   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (core_start) begin
            chk(core_block == exp_block(exp_start + 32'(k_core)), "R1 R2 R3", "block",
                core_block, exp_block(exp_start + 32'(k_core)));
            chk(core_counter == 64'd640, "R4", "counter", core_counter, 640);
            chk(core_chain == TB_IV, "R4", "chain", core_chain, TB_IV);
            chk(!dig_valid, "R7", "launch with pending digest", dig_valid, 0);
            k_core++;
         end
         if (stall_prev)
            chk(dig_valid && dig_data == stall_data, "R7", "stalled word held", dig_data, stall_data);
         if (dig_valid && dig_ready) begin
            chk(dig_data == exp_word(k_out, w), "R5", "digest word", dig_data, exp_word(k_out, w));
            chk(dig_slot == CNT_W'(k_out), "R6", "slot", dig_slot, k_out);
            chk(dig_last == (w == 15), "R5", "last flag", dig_last, (w == 15));
            w++;
            if (w == 16) begin w = 0; k_out++; end
         end
         stall_prev = dig_valid && !dig_ready;
         stall_data = dig_data;
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr_hdr(input int addr, input logic [31:0] data);
      @(posedge clk); #1;
      hdr_wr_en = 1'b1; hdr_wr_addr = 5'(addr); hdr_wr_data = data;
      @(posedge clk); #1;
      hdr_wr_en = 1'b0;
   endtask

   task automatic load_header(input logic [31:0] seed);
      for (int k = 0; k < 20; k++) begin
         hdr_mdl[k] = seed + 32'h9e3779b9 * 32'(k);
         wr_hdr(k, hdr_mdl[k]);
      end
   endtask

   task automatic run_sweep(input logic [31:0] seed, input logic [31:0] first, input int cnt,
                            input int md, input bit reload, input bit poke);
      int n;
      if (reload) load_header(seed);
      mode = md; exp_start = first; k_core = 0; k_out = 0; w = 0;
      @(posedge clk); #1;
      start_nonce = first; nonce_count = CNT_W'(cnt); sweep_start = 1'b1;
      @(posedge clk); #1;
      sweep_start = 1'b0;
      @(negedge clk);
      chk(!sweep_done && sweep_busy, "R8", "done cleared by start", sweep_done, 0);
      if (poke) begin
         repeat (3) @(posedge clk); #1;
         start_nonce = ~first; nonce_count = CNT_W'(cnt + 3); sweep_start = 1'b1;
         @(posedge clk); #1;
         sweep_start = 1'b0;
      end
      n = 0;
      while (!sweep_done && n < 5000) begin @(negedge clk); n++; end
      chk(sweep_done && !sweep_busy, "R8", "done after sweep", sweep_done, 1);
      chk(k_out == cnt && w == 0, poke ? "R10" : "R6", "digests streamed", k_out, cnt);
      chk(k_core == cnt, "R4", "core launches", k_core, cnt);
      repeat (3) @(negedge clk);
      chk(sweep_done && !dig_valid && !sweep_busy, "R8", "done held", sweep_done, 1);
   endtask

   initial begin
      repeat (4) @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R12
      chk(!dig_valid && !core_start && !sweep_busy && !sweep_done, "R12", "reset state",
          {dig_valid, core_start, sweep_busy, sweep_done}, 0);
      mon_en = 1'b1;

      // R9: zero-count sweep
      load_header(32'h55aa1234);
      k_core = 0; k_out = 0;
      @(posedge clk); #1;
      nonce_count = '0; start_nonce = 32'h77; sweep_start = 1'b1;
      @(posedge clk); #1;
      sweep_start = 1'b0;
      @(negedge clk);
      chk(sweep_done && !sweep_busy, "R9", "zero count done", sweep_done, 1);
      repeat (4) @(negedge clk);
      chk(k_core == 0 && k_out == 0 && !dig_valid, "R9", "zero count no work", k_core, 0);

      // Vector table: header seed, first nonce, count, back-pressure pattern
      for (int v = 0; v < NV; v++)
         run_sweep(V_SEED[v], V_START[v], V_CNT[v], V_MODE[v], 1'b1, 1'b0);

      // R6: wrap across 2^32 under heavy back-pressure
      run_sweep(32'h0f0f0f0f, 32'hffffffff, 2, 2, 1'b1, 1'b0);

      // R10: start pulse during a running sweep
      run_sweep(32'h31415926, 32'h00000100, 2, 1, 1'b1, 1'b1);

      // R11: writes at or above word 19 leave the header alone
      load_header(32'hfeedbeef);
      wr_hdr(19, 32'hdeadbeef);
      wr_hdr(20, 32'hffffffff);
      wr_hdr(23, 32'hffffffff);
      wr_hdr(31, 32'hffffffff);
      run_sweep(32'h0, 32'h00abcdef, 1, 0, 1'b0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule